// File: doc/BRIEF.md
# LCD Driver Drive-Time Controller

This block sets how long the LCD segment and common drivers stay switched on after each voltage transition. The frame logic sends a one-cycle strobe at every transition. The block then raises a registered driver enable for a number of clock cycles. That number is chosen by a 3-bit drive code and is never longer than half of the prescaled LCD clock period. The frame logic supplies that half period as a count of clock cycles.

Seven codes select fixed on-times. Each of these times is a parameter in clock cycles, derived from the clock frequency parameter `CLK_KHZ`. The eighth code selects exactly half the prescaled period. When the panel runs in static duty, or while it is blanked, the on-time is always the half period, whatever the code. A separate maximum-drive input holds the enable high for as long as it stays set.

The pulse length is fixed at the strobe that starts the pulse. A code change during a pulse therefore applies from the next strobe onward. A strobe that arrives during a pulse restarts the count with the length in force at that moment.

Top module: `lcd_drive_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `drv_en` is low. The counter starts with no pulse running.
- R2: A strobe with `drv_code` 0 through 6 gives an on-time of 300, 70, 150, 450, 575, 850 or 1150 µs, in that code order. Each time is converted to whole clock cycles as floor(µs × CLK_KHZ / 1000). With the default of 100 kHz this gives 30, 7, 15, 45, 57, 85 and 115 cycles.
- R3: `drv_code` 7 gives an on-time equal to `half_cycles`.
- R4: The on-time never exceeds `half_cycles`. A fixed time that is longer is cut to `half_cycles`.
- R5: While `static_duty` or `blank` is 1 at the strobe, the on-time equals `half_cycles`, whatever the code.
- R6: While `max_drive` is 1, `drv_en` is 1 from the next cycle onward, and the drive code has no effect on it.
- R7: The length is sampled when the strobe is taken. A code change during a pulse leaves that pulse unchanged, and the next strobe uses the new code.
- R8: A strobe during an active pulse restarts it with the full newly selected length.
- R9: If the selected length is 0 (`half_cycles` = 0), a strobe produces no pulse.
- R10: `drv_en` rises in the cycle after the clock edge that takes the strobe. It stays high for exactly the selected number of cycles and then falls, unless `max_drive` holds it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_stb | input | 1 | One-cycle strobe at each voltage transition |
| half_cycles | input | HW | Half of the prescaled LCD clock period, in clock cycles |
| drv_code | input | 3 | Drive-time code |
| max_drive | input | 1 | Keep the drivers on continuously |
| static_duty | input | 1 | Static duty mode: on-time is the half period |
| blank | input | 1 | Blanking: on-time is the half period |
| drv_en | output | 1 | Registered enable for the segment and common drivers |

## Verification
A wrong length table, clamp or mode override shows at the ports as an enable that falls one or more cycles too early or too late. This appears within the first pulse after the faulty selection, at most 115 cycles at the default clock. A counter that fails to restart, or fails to stop, shows within one cycle of the strobe, or as an enable that never falls. The bench keeps a behavioural countdown model, compares `drv_en` on every cycle, and so places each discrepancy in the exact cycle where it occurs.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int NUM_FIXED = 7;
  localparam logic [2:0] CODE_HALF = 3'd7;

  // Fixed on-time in microseconds for codes 0..6
  function automatic int fixed_us(input int idx);
    case (idx)
      0:       fixed_us = 300;
      1:       fixed_us = 70;
      2:       fixed_us = 150;
      3:       fixed_us = 450;
      4:       fixed_us = 575;
      5:       fixed_us = 850;
      default: fixed_us = 1150;
    endcase
  endfunction

  // Whole clock cycles for a fixed on-time at the given clock (kHz)
  function automatic int fixed_cycles(input int idx, input int clk_khz);
    fixed_cycles = (fixed_us(idx) * clk_khz) / 1000;
  endfunction

endpackage

// File: rtl/lcd_drv_len_sel.sv
module lcd_drv_len_sel
  import lcd_drv_pkg::*;
#(
  parameter int CLK_KHZ = 100,
  parameter int HW      = 16,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] half_cycles,
  input  logic [2:0]    drv_code,
  input  logic          static_duty,
  input  logic          blank,
  output logic [CW-1:0] len
);

  localparam int XW = (HW > CW) ? HW : CW;

  logic [XW-1:0] fixed_tab [NUM_FIXED];
  logic [XW-1:0] half_x;
  logic [XW-1:0] pick;
  logic [XW-1:0] clamped;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIXED; gi++) begin : g_tab
      assign fixed_tab[gi] = XW'(fixed_cycles(gi, CLK_KHZ));
    end
  endgenerate

  assign half_x = XW'(half_cycles);

  always_comb begin
    if (static_duty || blank || drv_code == CODE_HALF) begin
      pick = half_x;
    end else begin
      pick = fixed_tab[drv_code];
    end
    clamped = (pick > half_x) ? half_x : pick;
    len     = CW'(clamped);
  end

  // R4: selected length never above the half period
  p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    XW'(len) <= half_x);

  // R5: static or blank always gives the half period
  p_mode_half_r5: assert property (@(posedge clk) disable iff (rst)
    (static_duty || blank) |-> XW'(len) == half_x);

endmodule

// File: rtl/lcd_drv_timer.sv
module lcd_drv_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          busy_d,
  output logic          busy_q
);

  logic [CW-1:0] rem_q;
  logic [CW-1:0] rem_d;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    if (start) begin
      busy_d = (len != '0);
      rem_d  = (len != '0) ? len - CW'(1) : '0;
    end else if (busy_q) begin
      if (rem_q == '0) begin
        busy_d = 1'b0;
      end else begin
        rem_d = rem_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
    end
  end

  // R8: a strobe always restarts; busy follows the length it was given
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q == ($past(len) != '0));

  // R10: final count ends the pulse when no new strobe comes
  p_end_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rem_q == '0 && !start) |=> !busy_q);

  // R9: zero length never starts a pulse
  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (start && len == '0) |=> !busy_q);

endmodule

// File: rtl/lcd_drive_gate.sv
module lcd_drive_gate #(
  parameter int CLK_KHZ = 100,
  parameter int HW      = 16,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_stb,
  input  logic [HW-1:0] half_cycles,
  input  logic [2:0]    drv_code,
  input  logic          max_drive,
  input  logic          static_duty,
  input  logic          blank,
  output logic          drv_en
);

  logic [CW-1:0] len;
  logic          busy_d;
  logic          busy_q;

  lcd_drv_len_sel #(
    .CLK_KHZ(CLK_KHZ),
    .HW     (HW),
    .CW     (CW)
  ) u_len (
    .clk        (clk),
    .rst        (rst),
    .half_cycles(half_cycles),
    .drv_code   (drv_code),
    .static_duty(static_duty),
    .blank      (blank),
    .len        (len)
  );

  lcd_drv_timer #(
    .CW(CW)
  ) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (xfer_stb),
    .len   (len),
    .busy_d(busy_d),
    .busy_q(busy_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en <= 1'b0;
    end else begin
      drv_en <= max_drive | busy_d;
    end
  end

  // R1: reset clears the enable
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !drv_en);

  // R6: max drive holds the enable high
  p_max_on_r6: assert property (@(posedge clk) disable iff (rst)
    max_drive |=> drv_en);

  // R10: enable mirrors the pulse timer when max drive is off
  p_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !max_drive |=> drv_en == busy_q);

endmodule

// File: tb/test_lcd_drive_gate.sv
`timescale 1ns/1ps
module test_lcd_drive_gate;

  localparam int HW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_stb = 1'b0;
  logic [HW-1:0] half_cycles = '0;
  logic [2:0]    drv_code = 3'd0;
  logic          max_drive = 1'b0;
  logic          static_duty = 1'b0;
  logic          blank = 1'b0;
  logic          drv_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int left = 0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  lcd_drive_gate i_lcd_drive_gate (
    .clk(clk), .rst(rst), .xfer_stb(xfer_stb), .half_cycles(half_cycles),
    .drv_code(drv_code), .max_drive(max_drive), .static_duty(static_duty),
    .blank(blank), .drv_en(drv_en)
  );

  function automatic int want_len(input int code, input int half,
                                  input bit st, input bit bl);
    int us [7] = '{300, 70, 150, 450, 575, 850, 1150};
    int v;
    if (st || bl || code == 7) v = half;
    else v = us[code] * 100 / 1000;
    if (v > half) v = half;
    return v;
  endfunction

  // Reference model: cycles of enable remaining
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) left <= 0;
    else if (xfer_stb) left <= want_len(drv_code, half_cycles, static_duty, blank);
    else if (left > 0) left <= left - 1;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp;
      exp = max_drive_q || (left > 0);
      checks++;
      if (drv_en !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d drv_en=%b expected=%b", tag, cyc, drv_en, exp);
      end
    end
  end

  logic max_drive_q = 1'b0;
  always @(posedge clk) max_drive_q <= rst ? 1'b0 : max_drive;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input int code, input int half, input bit st, input bit bl);
    drv_code = code[2:0]; half_cycles = half[HW-1:0]; static_duty = st; blank = bl;
    xfer_stb = 1'b1;
    @(negedge clk);
    xfer_stb = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (drv_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 drv_en=%b expected=0 during reset", drv_en);
    end
    rst = 1'b0;
    tag = "R1"; idle(3);
    tag = "R2";
    for (int c = 0; c < 7; c++) begin
      strobe(c, 500, 0, 0); idle(125);
    end
    tag = "R3"; strobe(7, 40, 0, 0); idle(45);
    tag = "R4"; strobe(6, 60, 0, 0); idle(65);
    strobe(0, 29, 0, 0); idle(35);
    tag = "R5"; strobe(1, 50, 1, 0); idle(55);
    strobe(6, 20, 0, 1); idle(25);
    tag = "R6"; max_drive = 1'b1; idle(4);
    strobe(1, 10, 0, 0); idle(20); drv_code = 3'd5; idle(5);
    max_drive = 1'b0; idle(5);
    tag = "R7"; strobe(2, 300, 0, 0); drv_code = 3'd1; idle(20);
    strobe(1, 300, 0, 0); idle(10);
    tag = "R8"; strobe(0, 300, 0, 0); idle(10); strobe(1, 300, 0, 0); idle(3);
    strobe(2, 300, 0, 0); idle(20);
    tag = "R9"; strobe(7, 0, 0, 0); idle(4); strobe(3, 0, 1, 0); idle(4);
    tag = "R10"; strobe(7, 1, 0, 0); idle(3); strobe(7, 2, 0, 0); idle(4);
    finish_run();
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog cycle=%0d expected end before 100000", cyc);
    finish_run();
  end

endmodule